// File: doc/BRIEF.md
# System-Management Base Relocation Controller

This block holds the base address of the system-management memory area and carries out the short memory sequences that surround each entry into and exit from system management mode. From the base it derives the handler entry address (base plus 8000H) and the last address of the state-save area (base plus FFFFH). On an entry pulse it stores the live base into a fixed save slot of the area and clears an I/O-restart slot. On a resume pulse it reads both slots back. A 32 KB aligned slot value becomes the base for the next entry. A misaligned value stops the block in a shutdown state.

The handler moves the area by rewriting the base slot before it resumes. The handler requests a restart of a trapped I/O instruction by writing FFH into the restart slot. An entry request that arrives while the block is in system management mode is held. It starts the moment the resume sequence completes. The handler of such a back-to-back entry must leave the restart slot at 00H. If it does not, the block reports a protocol error. A soft reset returns the control state to idle but keeps the base register. Only the hard reset restores the base.

Top module: `smm_base_reloc`

## Requirements
- R1: After hard reset (rstHardN low, asynchronous) the base is 0003_0000H, so jumpVector is 0003_8000H and saveTop is 0003_FFFFH. inSmm, shutdown, done and memValid are 0.
- R2: At all times jumpVector equals base + 8000H, and saveTop equals base + FFFFH.
- R3: An smiPulse in idle starts the entry sequence. Two writes follow in order: the base to jumpVector + 7EF8H, then 0000_0000H to the restart slot at jumpVector + 7F00H. Each request holds memValid, memAddr and memWrite steady until memReady. done pulses for one cycle in the cycle after the last handshake, and inSmm is 1 from that cycle on.
- R4: An rsmPulse while inSmm is 1 starts the resume sequence. Two reads follow: the restart slot first, then the base slot. If bits 14:0 of the base-slot data are all zero, that value becomes the base. jumpVector shows the new base in the same cycle as done, which comes one cycle after the last handshake. inSmm is then 0.
- R5: If bits 14:0 of the base-slot data are not all zero, the base is kept and shutdown goes to 1 in the done cycle. It stays at 1 until a hard or soft reset. While shutdown is 1, inSmm and memValid stay 0 and smiPulse has no effect.
- R6: restartIo pulses together with the resume done only when bits 7:0 of the restart-slot data are FFH. With 00H it stays 0.
- R7: An smiPulse while in system management mode is held pending. This includes the cycle in which the last resume read completes. The held entry starts in the done cycle of that resume, with memValid at 1 and the addresses of the newly loaded base. If the resume of such a back-to-back entry reads FFH from the restart slot, protoErr pulses with its done.
- R8: An rsmPulse while inSmm is 0 has no effect. memValid and inSmm stay 0.
- R9: A soft reset (softRst high for one cycle) returns the block to idle and clears inSmm, shutdown and any held entry. jumpVector and saveTop stay unchanged.
- R10: revId is a constant revision identifier with bit 17 set to show that relocation is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstHardN | input | 1 | Hard reset, asynchronous, active low; restores the base |
| softRst | input | 1 | Synchronous soft reset; keeps the base |
| smiPulse | input | 1 | One-cycle entry request |
| rsmPulse | input | 1 | One-cycle resume request |
| memValid | output | 1 | Slot access request |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Slot address |
| memWdata | output | 32 | Write data |
| memReady | input | 1 | Access accepted this cycle |
| memRdata | input | 32 | Read data, valid with memReady |
| jumpVector | output | 32 | Handler entry address |
| saveTop | output | 32 | Last address of the save area |
| revId | output | 32 | Revision identifier, bit 17 set |
| inSmm | output | 1 | In system management mode |
| done | output | 1 | One-cycle end-of-sequence pulse |
| restartIo | output | 1 | Restart trapped I/O, pulses with resume done |
| protoErr | output | 1 | Restart requested by a back-to-back handler |
| shutdown | output | 1 | Misaligned base seen; sticky |

## Verification
Two things can happen in the same cycle: the last read of a resume completes, and a new entry request arrives. The bench raises smiPulse in the same cycle that it returns memReady for the base-slot read. It expects memValid to be up in the done cycle and to carry the write to the newly loaded base's save slot. Later it expects protoErr when that back-to-back handler leaves FFH in the restart slot. A second case holds an entry that was requested earlier in the mode. It is judged the same way, except that protoErr must stay low when the handler writes 00H.

// File: rtl/smm_reloc_pkg.sv
package smm_reloc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_EBASE, ST_EIO, ST_INSMM, ST_RIO, ST_RBASE, ST_SHUT
  } smmState_t;

  typedef struct packed {
    logic selIo;     // address the restart slot instead of the base slot
    logic loadBase;  // take read data as the new base
  } dpStrobe_t;
endpackage

// File: rtl/smm_reloc_dp.sv
module smm_reloc_dp
  import smm_reloc_pkg::*;
#(
  parameter int          W          = 32,
  parameter int          ALIGN_BITS = 15,
  parameter logic [31:0] RESET_BASE = 32'h0003_0000,
  parameter logic [31:0] AREA_OFS   = 32'h0000_8000,
  parameter logic [31:0] AREA_LAST  = 32'h0000_7FFF,
  parameter logic [31:0] BASE_SLOT  = 32'h0000_7EF8,
  parameter logic [31:0] IO_SLOT    = 32'h0000_7F00
) (
  input  logic         clk,
  input  logic         rstHardN,
  input  dpStrobe_t    strobe,
  input  logic [W-1:0] memRdata,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  output logic [W-1:0] jumpVector,
  output logic [W-1:0] saveTop,
  output logic         rdAligned,
  output logic         rdRestart
);
  localparam logic [W-1:0] BASE_INIT = W'(RESET_BASE);
  localparam logic [W-1:0] VEC_OFS   = W'(AREA_OFS);
  localparam logic [W-1:0] TOP_OFS   = W'(AREA_OFS) + W'(AREA_LAST);

  logic [W-1:0] baseQ;

  // base register: only the hard reset restores it
  always_ff @(posedge clk or negedge rstHardN) begin
    if (!rstHardN)           baseQ <= BASE_INIT;
    else if (strobe.loadBase) baseQ <= memRdata;
  end

  assign jumpVector = baseQ + VEC_OFS;
  assign saveTop    = baseQ + TOP_OFS;
  assign memAddr    = jumpVector + (strobe.selIo ? W'(IO_SLOT) : W'(BASE_SLOT));
  assign memWdata   = strobe.selIo ? '0 : baseQ;
  assign rdAligned  = (memRdata[ALIGN_BITS-1:0] == '0);
  assign rdRestart  = (memRdata[7:0] == 8'hFF);
endmodule

// File: rtl/smm_reloc_ctl.sv
module smm_reloc_ctl
  import smm_reloc_pkg::*;
(
  input  logic      clk,
  input  logic      rstHardN,
  input  logic      softRst,
  input  logic      smiPulse,
  input  logic      rsmPulse,
  input  logic      memReady,
  input  logic      rdAligned,
  input  logic      rdRestart,
  output dpStrobe_t strobe,
  output logic      memValid,
  output logic      memWrite,
  output logic      inSmm,
  output logic      done,
  output logic      restartIo,
  output logic      protoErr,
  output logic      shutdown
);
  smmState_t state, stateNext;
  logic pending, b2bEntry, ioReq;
  logic xfer, lastRead, busy;

  assign memValid = (state == ST_EBASE) || (state == ST_EIO) ||
                    (state == ST_RIO)   || (state == ST_RBASE);
  assign memWrite = (state == ST_EBASE) || (state == ST_EIO);
  assign inSmm    = (state == ST_INSMM) || (state == ST_RIO) || (state == ST_RBASE);
  assign shutdown = (state == ST_SHUT);
  assign busy     = (state != ST_IDLE) && (state != ST_SHUT);
  assign xfer     = memValid && memReady;
  assign lastRead = (state == ST_RBASE) && xfer;

  assign strobe.selIo    = (state == ST_EIO) || (state == ST_RIO);
  assign strobe.loadBase = lastRead && rdAligned && !softRst;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (smiPulse) stateNext = ST_EBASE;
      ST_EBASE: if (xfer) stateNext = ST_EIO;
      ST_EIO:   if (xfer) stateNext = ST_INSMM;
      ST_INSMM: if (rsmPulse) stateNext = ST_RIO;
      ST_RIO:   if (xfer) stateNext = ST_RBASE;
      ST_RBASE: if (xfer) begin
        if (!rdAligned)                stateNext = ST_SHUT;
        else if (pending || smiPulse)  stateNext = ST_EBASE;
        else                           stateNext = ST_IDLE;
      end
      ST_SHUT:  stateNext = ST_SHUT;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstHardN) begin
    if (!rstHardN) begin
      state     <= ST_IDLE;
      pending   <= 1'b0;
      b2bEntry  <= 1'b0;
      ioReq     <= 1'b0;
      done      <= 1'b0;
      restartIo <= 1'b0;
      protoErr  <= 1'b0;
    end else if (softRst) begin
      state     <= ST_IDLE;
      pending   <= 1'b0;
      b2bEntry  <= 1'b0;
      ioReq     <= 1'b0;
      done      <= 1'b0;
      restartIo <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      state     <= stateNext;
      done      <= ((state == ST_EIO) && xfer) || lastRead;
      restartIo <= lastRead && ioReq;
      protoErr  <= lastRead && ioReq && b2bEntry;
      if (lastRead)                     pending <= 1'b0;
      else if (smiPulse && busy)        pending <= 1'b1;
      if ((state == ST_RIO) && xfer)    ioReq <= rdRestart;
      if (state == ST_IDLE && smiPulse) b2bEntry <= 1'b0;
      else if (lastRead && stateNext == ST_EBASE) b2bEntry <= 1'b1;
    end
  end
endmodule

// File: rtl/smm_base_reloc.sv
module smm_base_reloc
  import smm_reloc_pkg::*;
#(
  parameter int          W          = 32,
  parameter int          ALIGN_BITS = 15,
  parameter logic [31:0] RESET_BASE = 32'h0003_0000,
  parameter logic [31:0] AREA_OFS   = 32'h0000_8000,
  parameter logic [31:0] AREA_LAST  = 32'h0000_7FFF,
  parameter logic [31:0] BASE_SLOT  = 32'h0000_7EF8,
  parameter logic [31:0] IO_SLOT    = 32'h0000_7F00,
  parameter logic [31:0] REV_LOW    = 32'h0000_0010,
  parameter int          RELOC_BIT  = 17
) (
  input  logic         clk,
  input  logic         rstHardN,
  input  logic         softRst,
  input  logic         smiPulse,
  input  logic         rsmPulse,
  output logic         memValid,
  output logic         memWrite,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  input  logic         memReady,
  input  logic [W-1:0] memRdata,
  output logic [W-1:0] jumpVector,
  output logic [W-1:0] saveTop,
  output logic [W-1:0] revId,
  output logic         inSmm,
  output logic         done,
  output logic         restartIo,
  output logic         protoErr,
  output logic         shutdown
);
  localparam logic [W-1:0] REV_ID = W'(REV_LOW) | (W'(1) << RELOC_BIT);

  dpStrobe_t strobe;
  logic      rdAligned, rdRestart;

  assign revId = REV_ID;

  smm_reloc_ctl u_ctl (
    .clk(clk), .rstHardN(rstHardN), .softRst(softRst),
    .smiPulse(smiPulse), .rsmPulse(rsmPulse), .memReady(memReady),
    .rdAligned(rdAligned), .rdRestart(rdRestart), .strobe(strobe),
    .memValid(memValid), .memWrite(memWrite), .inSmm(inSmm), .done(done),
    .restartIo(restartIo), .protoErr(protoErr), .shutdown(shutdown)
  );

  smm_reloc_dp #(
    .W(W), .ALIGN_BITS(ALIGN_BITS), .RESET_BASE(RESET_BASE),
    .AREA_OFS(AREA_OFS), .AREA_LAST(AREA_LAST),
    .BASE_SLOT(BASE_SLOT), .IO_SLOT(IO_SLOT)
  ) u_dp (
    .clk(clk), .rstHardN(rstHardN), .strobe(strobe), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .jumpVector(jumpVector),
    .saveTop(saveTop), .rdAligned(rdAligned), .rdRestart(rdRestart)
  );
endmodule

// File: rtl/smm_base_reloc_chk.sv
module smm_base_reloc_chk #(
  parameter int          W         = 32,
  parameter logic [31:0] AREA_OFS  = 32'h0000_8000,
  parameter logic [31:0] AREA_LAST = 32'h0000_7FFF,
  parameter logic [31:0] BASE_SLOT = 32'h0000_7EF8
) (
  input logic         clk,
  input logic         rstHardN,
  input logic         softRst,
  input logic         smiPulse,
  input logic         rsmPulse,
  input logic         memValid,
  input logic         memWrite,
  input logic [W-1:0] memAddr,
  input logic [W-1:0] memWdata,
  input logic         memReady,
  input logic [W-1:0] jumpVector,
  input logic [W-1:0] saveTop,
  input logic         inSmm,
  input logic         done,
  input logic         shutdown
);
  p_window_r2: assert property (@(posedge clk) disable iff (!rstHardN)
    (jumpVector[14:0] == 15'd0) && (saveTop == jumpVector + W'(AREA_LAST)));

  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rstHardN || softRst)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memWrite));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstHardN)
    done |=> !done);

  p_slot_write_r3: assert property (@(posedge clk) disable iff (!rstHardN)
    memValid && memWrite && (memAddr == jumpVector + W'(BASE_SLOT))
      |-> memWdata == jumpVector - W'(AREA_OFS));

  p_shut_sticky_r5: assert property (@(posedge clk) disable iff (!rstHardN)
    shutdown && !softRst |=> shutdown);

  p_shut_quiet_r5: assert property (@(posedge clk) disable iff (!rstHardN)
    shutdown |-> !memValid && !inSmm);

  p_rsm_ignored_r8: assert property (@(posedge clk) disable iff (!rstHardN || softRst)
    rsmPulse && !smiPulse && !inSmm && !memValid && !shutdown |=> !memValid && !inSmm);

  p_base_kept_r9: assert property (@(posedge clk) disable iff (!rstHardN)
    softRst |=> $stable(jumpVector));
endmodule

bind smm_base_reloc smm_base_reloc_chk #(.W(W), .AREA_OFS(AREA_OFS),
  .AREA_LAST(AREA_LAST), .BASE_SLOT(BASE_SLOT)) u_chk (.*);

// File: tb/smm_base_reloc_bench.sv
`timescale 1ns/1ps
module smm_base_reloc_bench;
  logic        clk = 1'b0;
  logic        rstHardN, softRst, smiPulse, rsmPulse, memReady;
  logic [31:0] memRdata, memAddr, memWdata, jumpVector, saveTop, revId;
  logic        memValid, memWrite, inSmm, done, restartIo, protoErr, shutdown;

  int nChecks = 0, nFails = 0;
  logic [31:0] mBase;
  logic        smiWithReady = 1'b0;

  always #2 clk = ~clk;

  smm_base_reloc u_smm_base_reloc (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic serve(input logic [31:0] expA, input logic expW, input logic [31:0] expD,
                       input logic [31:0] rd, input int lat, input string req);
    for (int i = 0; i < lat; i++) begin
      chk(req, "valid while waiting", 32'(memValid), 32'd1);
      @(negedge clk);
    end
    chk(req, "valid", 32'(memValid), 32'd1);
    chk(req, "addr", memAddr, expA);
    chk(req, "write", 32'(memWrite), 32'(expW));
    if (expW) chk(req, "wdata", memWdata, expD);
    memReady = 1'b1; memRdata = rd;
    if (smiWithReady) smiPulse = 1'b1;
    @(negedge clk);
    memReady = 1'b0; memRdata = '0; smiPulse = 1'b0; smiWithReady = 1'b0;
  endtask

  task automatic entrySeq(input int lat);
    serve(mBase + 32'h8000 + 32'h7EF8, 1'b1, mBase, '0, lat, "R3");
    serve(mBase + 32'h8000 + 32'h7F00, 1'b1, 32'h0, '0, lat, "R3");
    chk("R3", "done", 32'(done), 32'd1);
    chk("R3", "inSmm", 32'(inSmm), 32'd1);
    @(negedge clk);
    chk("R3", "done pulse width", 32'(done), 32'd0);
  endtask

  task automatic doEntry(input int lat);
    smiPulse = 1'b1; @(negedge clk); smiPulse = 1'b0;
    entrySeq(lat);
  endtask

  task automatic doResume(input logic [31:0] ioV, input logic [31:0] baseV, input int lat,
                          input bit wasB2b, input bit nextEntry, input bit smiSame);
    bit aligned;
    bit ioFF;
    aligned = (baseV[14:0] == 15'd0);
    ioFF = (ioV[7:0] == 8'hFF);
    rsmPulse = 1'b1; @(negedge clk); rsmPulse = 1'b0;
    serve(mBase + 32'h8000 + 32'h7F00, 1'b0, '0, ioV, lat, "R4");
    smiWithReady = smiSame;
    serve(mBase + 32'h8000 + 32'h7EF8, 1'b0, '0, baseV, lat, "R4");
    if (aligned) mBase = baseV;
    chk("R4", "resume done", 32'(done), 32'd1);
    chk("R4", "inSmm after resume", 32'(inSmm), 32'd0);
    chk("R2", "jumpVector", jumpVector, mBase + 32'h8000);
    chk("R2", "saveTop", saveTop, mBase + 32'hFFFF);
    chk("R5", "shutdown", 32'(shutdown), 32'(!aligned));
    chk("R6", "restartIo", 32'(restartIo), 32'(ioFF));
    chk("R7", "protoErr", 32'(protoErr), 32'(wasB2b && ioFF));
    chk("R7", "held entry start", 32'(memValid), 32'(aligned && (nextEntry || smiSame)));
    @(negedge clk);
    chk("R6", "restartIo pulse width", 32'(restartIo), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    rstHardN = 1'b0; softRst = 1'b0; smiPulse = 1'b0; rsmPulse = 1'b0;
    memReady = 1'b0; memRdata = '0;
    mBase = 32'h0003_0000;
    repeat (3) @(negedge clk);
    rstHardN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "jumpVector", jumpVector, 32'h0003_8000);
    chk("R1", "saveTop", saveTop, 32'h0003_FFFF);
    chk("R1", "inSmm", 32'(inSmm), 32'd0);
    chk("R1", "shutdown", 32'(shutdown), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "memValid", 32'(memValid), 32'd0);
    chk("R10", "revId reloc bit", 32'(revId[17]), 32'd1);

    // R8 resume outside the mode
    rsmPulse = 1'b1; @(negedge clk); rsmPulse = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R8", "memValid", 32'(memValid), 32'd0);
      chk("R8", "inSmm", 32'(inSmm), 32'd0);
      @(negedge clk);
    end

    // sweep of aligned relocations, restart slot alternating
    for (int j = 0; j < 16; j++) begin
      doEntry(j % 3);
      doResume((j % 2) ? 32'h0000_00FF : 32'h0, (32'(j) << 15) | (32'(j) << 21),
               (j + 1) % 3, 1'b0, 1'b0, 1'b0);
    end

    // R7 entry held from earlier in the mode
    doEntry(1);
    smiPulse = 1'b1; @(negedge clk); smiPulse = 1'b0;
    chk("R7", "held, still in mode", 32'(inSmm), 32'd1);
    doResume(32'h0, 32'h0004_8000, 1, 1'b0, 1'b1, 1'b0);
    entrySeq(0);
    // R7 request in the same cycle as the final resume read
    doResume(32'h0000_00FF, 32'h0005_0000, 0, 1'b1, 1'b0, 1'b1);
    entrySeq(2);
    doResume(32'h0000_00FF, 32'h0006_8000, 1, 1'b1, 1'b0, 1'b0);
    doEntry(0);
    doResume(32'h0000_00FF, 32'h0006_8000, 0, 1'b0, 1'b0, 1'b0);

    // R5 / R9 sweep over every misaligned low bit
    for (int k = 0; k < 15; k++) begin
      doEntry(k % 2);
      doResume(32'h0, mBase | (32'd1 << k), k % 3, 1'b0, 1'b0, 1'b0);
      chk("R5", "inSmm in shutdown", 32'(inSmm), 32'd0);
      smiPulse = 1'b1; @(negedge clk); smiPulse = 1'b0;
      @(negedge clk);
      chk("R5", "entry ignored", 32'(memValid), 32'd0);
      chk("R5", "shutdown sticky", 32'(shutdown), 32'd1);
      softRst = 1'b1; @(negedge clk); softRst = 1'b0;
      chk("R9", "shutdown cleared", 32'(shutdown), 32'd0);
      chk("R9", "base kept", jumpVector, mBase + 32'h8000);
    end

    // R9 soft reset inside the mode drops a held entry
    doEntry(1);
    smiPulse = 1'b1; @(negedge clk); smiPulse = 1'b0;
    softRst = 1'b1; @(negedge clk); softRst = 1'b0;
    chk("R9", "inSmm cleared", 32'(inSmm), 32'd0);
    chk("R9", "held entry dropped", 32'(memValid), 32'd0);
    chk("R9", "base kept in mode", saveTop, mBase + 32'hFFFF);
    @(negedge clk);
    chk("R9", "still idle", 32'(memValid), 32'd0);

    // R1 hard reset restores the base
    rstHardN = 1'b0; @(negedge clk); rstHardN = 1'b1; @(negedge clk);
    mBase = 32'h0003_0000;
    chk("R1", "base restored", jumpVector, 32'h0003_8000);
    doEntry(0);
    doResume(32'h0, 32'h0003_0000, 0, 1'b0, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule